// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This block is the interrupt core of a memory-mapped SD host controller. It collects single-cycle event pulses from the command sequencer, the data/DMA engine and the card-detect logic. It holds them in a sticky raw status word, gates them through a software mask and a global enable, and drives one level-sensitive interrupt line toward the system interrupt controller. A separate DMA status word records transmit and receive completion together with a summary flag. A card-present flag in the status word follows the most recent insert or remove event.

Software reaches the block through a simple 32-bit register port with one write strobe and a byte address. Read data is registered and appears one clock after the address is presented. Status bits are cleared by writing ones to them. The interrupt line is computed from the next-state values of the registers, so it changes at the same clock edge as the state that causes the change.

Top module: `sdh_irq_core`

## Requirements
- R1: After reset the control word reads 0x00000300, the status word reads 0x00000100 (bit 8, card present, set), and the mask, raw status, masked status and DMA status words read zero. The interrupt line is low.
- R2: A write to the control word (offset 0x00) stores the value, except that bits 0, 1 and 2 (the reset request bits) always read back as zero.
- R3: Each event pulse sets its own raw status bit, and the bit stays set until software clears it. The bit positions are: no-response at bit 1, command done at bit 2, data done at bit 3, auto-command done at bit 14 and SDIO at bit 16.
- R4: A write to the raw status offset (0x0C) or to the masked status offset (0x10) clears every raw bit written as 1. All other raw bits keep their value.
- R5: Reading the masked status offset (0x10) returns the raw status ANDed with the mask word (offset 0x08).
- R6: The interrupt line is high exactly when control bit 4 is set and the masked status is nonzero. It updates at the same clock edge as the register change that causes it, so it changes one cycle after the input.
- R7: A card-insert pulse sets raw bit 30, clears raw bit 31 and sets status bit 8. A card-remove pulse sets raw bit 31, clears raw bit 30 and clears status bit 8. If both pulses arrive in the same cycle, the remove pulse takes effect.
- R8: In the DMA status word (offset 0x18), a transmit pulse sets bits 0 and 8 and a receive pulse sets bits 1 and 8. A write clears only the bits in [9:0] that are written as 1. Written bits at position 10 and above have no effect.
- R9: When an event sets a bit in the same cycle that a software write clears that bit, the bit ends up set. This holds for the raw status, the DMA status and the card-present flag.
- R10: Reads of an unmapped offset return zero, and writes to an unmapped offset change no register.
- R11: Writing 1 to bit 8 of the status word (offset 0x14) clears the card-present flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, one cycle after the address |
| ev_cmd_done | input | 1 | Command complete pulse |
| ev_no_resp | input | 1 | No-response pulse |
| ev_data_done | input | 1 | Data transfer complete pulse |
| ev_autocmd_done | input | 1 | Automatic stop command complete pulse |
| ev_sdio | input | 1 | SDIO interrupt pulse |
| ev_card_ins | input | 1 | Card inserted pulse |
| ev_card_rem | input | 1 | Card removed pulse |
| ev_dma_tx | input | 1 | DMA transmit complete pulse |
| ev_dma_rx | input | 1 | DMA receive complete pulse |
| irq | output | 1 | Level interrupt output |

## Verification
Two functions can land in the same cycle: a hardware event setting a status bit and a software write-one-to-clear of the same word. The bench drives an event pulse in the same cycle as a clear write of all ones, both to the raw status word and to the DMA status word. It then checks that only the newly raised bits survive while every older bit is cleared. Simultaneous insert and remove pulses are judged the same way, through the raw card bits and the present flag.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  localparam int DW = 32;

  // raw status bit positions
  localparam int BIT_NO_RESP   = 1;
  localparam int BIT_CMD_DONE  = 2;
  localparam int BIT_DATA_DONE = 3;
  localparam int BIT_AUTOCMD   = 14;
  localparam int BIT_SDIO      = 16;
  localparam int BIT_CARD_INS  = 30;
  localparam int BIT_CARD_REM  = 31;

  // control word
  localparam int CTRL_IRQ_EN_BIT = 4;
  localparam int CTRL_RST_REQ_W  = 3;
  localparam logic [DW-1:0] CTRL_RESET = 32'h0000_0300;

  // status word
  localparam int STAT_PRESENT_BIT = 8;

  // DMA status word
  localparam int DMA_TX_BIT  = 0;
  localparam int DMA_RX_BIT  = 1;
  localparam int DMA_SUM_BIT = 8;
  localparam int DMA_CLR_W   = 10;

  // register offsets
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_MASK  = 'h08;
  localparam int OFF_RAW   = 'h0C;
  localparam int OFF_MSKD  = 'h10;
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_DMA   = 'h18;

  // one W1C bit whose set input wins over a same-cycle clear
  function automatic logic sticky_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/sdh_irq_raw.sv
module sdh_irq_raw
  import sdh_irq_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         card_ins,
  input  logic         card_rem,
  input  logic         clr_we,
  input  logic [W-1:0] clr_val,
  input  logic         pres_clr,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] raw_nxt,
  output logic         pres_q,
  output logic         pres_nxt
);

  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_val : '0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == BIT_CARD_REM) begin : g_rem
      always_comb begin
        if (card_rem)      raw_nxt[b] = 1'b1;
        else if (card_ins) raw_nxt[b] = 1'b0;
        else               raw_nxt[b] = sticky_next(raw_q[b], set_vec[b], clr_eff[b]);
      end
    end else if (b == BIT_CARD_INS) begin : g_ins
      always_comb begin
        if (card_rem)      raw_nxt[b] = 1'b0;
        else if (card_ins) raw_nxt[b] = 1'b1;
        else               raw_nxt[b] = sticky_next(raw_q[b], set_vec[b], clr_eff[b]);
      end
    end else begin : g_plain
      assign raw_nxt[b] = sticky_next(raw_q[b], set_vec[b], clr_eff[b]);
    end
  end

  always_comb begin
    if (card_rem)      pres_nxt = 1'b0;
    else if (card_ins) pres_nxt = 1'b1;
    else               pres_nxt = pres_q & ~pres_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      pres_q <= 1'b1;
    end else begin
      raw_q  <= raw_nxt;
      pres_q <= pres_nxt;
    end
  end

endmodule

// File: rtl/sdh_irq_dma.sv
module sdh_irq_dma
  import sdh_irq_pkg::*;
#(
  parameter int W     = DW,
  parameter int CLR_W = DMA_CLR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_val,
  output logic [W-1:0]     dma_q
);

  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] dma_nxt;

  always_comb begin
    set_vec = '0;
    set_vec[DMA_TX_BIT]  = tx_done;
    set_vec[DMA_RX_BIT]  = rx_done;
    set_vec[DMA_SUM_BIT] = tx_done | rx_done;
  end

  // only the low window is writable; bits above are never cleared
  assign clr_vec = clr_we ? {{(W-CLR_W){1'b0}}, clr_val} : '0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign dma_nxt[b] = sticky_next(dma_q[b], set_vec[b], clr_vec[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) dma_q <= '0;
    else     dma_q <= dma_nxt;
  end

endmodule

// File: rtl/sdh_irq_gate.sv
module sdh_irq_gate #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_nxt,
  input  logic [W-1:0] raw_nxt,
  input  logic [W-1:0] mask_nxt,
  output logic         irq_q
);

  logic pend_nxt;
  assign pend_nxt = en_nxt && (|(raw_nxt & mask_nxt));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend_nxt;
  end

endmodule

// File: rtl/sdh_irq_core.sv
module sdh_irq_core
  import sdh_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ev_cmd_done,
  input  logic              ev_no_resp,
  input  logic              ev_data_done,
  input  logic              ev_autocmd_done,
  input  logic              ev_sdio,
  input  logic              ev_card_ins,
  input  logic              ev_card_rem,
  input  logic              ev_dma_tx,
  input  logic              ev_dma_rx,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(OFF_MSKD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(OFF_DMA);

  // write decode
  logic we_ctrl, we_mask, we_raw, we_stat, we_dma;
  assign we_ctrl = reg_we && (reg_addr == A_CTRL);
  assign we_mask = reg_we && (reg_addr == A_MASK);
  assign we_raw  = reg_we && ((reg_addr == A_RAW) || (reg_addr == A_MSKD));
  assign we_stat = reg_we && (reg_addr == A_STAT);
  assign we_dma  = reg_we && (reg_addr == A_DMA);

  // control and mask words
  logic [DW-1:0] ctrl_q, ctrl_nxt;
  logic [DW-1:0] mask_q, mask_nxt;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (we_ctrl) ctrl_nxt = {reg_wdata[DW-1:CTRL_RST_REQ_W], {CTRL_RST_REQ_W{1'b0}}};
  end

  assign mask_nxt = we_mask ? reg_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      mask_q <= mask_nxt;
    end
  end

  // raw status and card presence
  logic [DW-1:0] set_vec;
  logic [DW-1:0] raw_q, raw_nxt;
  logic          pres_q, pres_nxt;

  always_comb begin
    set_vec = '0;
    set_vec[BIT_NO_RESP]   = ev_no_resp;
    set_vec[BIT_CMD_DONE]  = ev_cmd_done;
    set_vec[BIT_DATA_DONE] = ev_data_done;
    set_vec[BIT_AUTOCMD]   = ev_autocmd_done;
    set_vec[BIT_SDIO]      = ev_sdio;
  end

  sdh_irq_raw #(.W(DW)) u_raw (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .card_ins (ev_card_ins),
    .card_rem (ev_card_rem),
    .clr_we   (we_raw),
    .clr_val  (reg_wdata),
    .pres_clr (we_stat & reg_wdata[STAT_PRESENT_BIT]),
    .raw_q    (raw_q),
    .raw_nxt  (raw_nxt),
    .pres_q   (pres_q),
    .pres_nxt (pres_nxt)
  );

  // DMA status
  logic [DW-1:0] dma_q;

  sdh_irq_dma #(.W(DW), .CLR_W(DMA_CLR_W)) u_dma (
    .clk     (clk),
    .rst     (rst),
    .tx_done (ev_dma_tx),
    .rx_done (ev_dma_rx),
    .clr_we  (we_dma),
    .clr_val (reg_wdata[DMA_CLR_W-1:0]),
    .dma_q   (dma_q)
  );

  // interrupt line from next-state values
  sdh_irq_gate #(.W(DW)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .en_nxt   (ctrl_nxt[CTRL_IRQ_EN_BIT]),
    .raw_nxt  (raw_nxt),
    .mask_nxt (mask_nxt),
    .irq_q    (irq)
  );

  // registered readback
  logic [DW-1:0] stat_word;
  logic [DW-1:0] rd_mux;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_PRESENT_BIT] = pres_q;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_MASK:  rd_mux = mask_q;
      A_RAW:   rd_mux = raw_q;
      A_MSKD:  rd_mux = raw_q & mask_q;
      A_STAT:  rd_mux = stat_word;
      A_DMA:   rd_mux = dma_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/sdh_irq_core_chk.sv
module sdh_irq_core_chk
  import sdh_irq_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          ev_cmd_done,
  input logic          ev_card_ins,
  input logic          ev_card_rem,
  input logic          ev_dma_tx,
  input logic          ev_dma_rx,
  input logic          irq,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] raw_q,
  input logic          pres_q,
  input logic [DW-1:0] dma_q
);

  AST_IRQ_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_q[CTRL_IRQ_EN_BIT] && (|(raw_q & mask_q)))); // R6

  AST_CTRL_REQ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTRL_RST_REQ_W-1:0] == '0); // R2

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_done |=> raw_q[BIT_CMD_DONE]); // R9

  AST_CARD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(raw_q[BIT_CARD_INS] && raw_q[BIT_CARD_REM])); // R7

  AST_INSERT_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (ev_card_ins && !ev_card_rem) |=> (pres_q && raw_q[BIT_CARD_INS])); // R7

  AST_REMOVE_ABSENT: assert property (@(posedge clk) disable iff (rst)
    ev_card_rem |=> (!pres_q && raw_q[BIT_CARD_REM])); // R7

  AST_DMA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    dma_q[DW-1:DMA_CLR_W] == '0); // R8

  AST_DMA_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    (ev_dma_tx || ev_dma_rx) |=> dma_q[DMA_SUM_BIT]); // R8

endmodule

bind sdh_irq_core sdh_irq_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_cmd_done (ev_cmd_done),
  .ev_card_ins (ev_card_ins),
  .ev_card_rem (ev_card_rem),
  .ev_dma_tx   (ev_dma_tx),
  .ev_dma_rx   (ev_dma_rx),
  .irq         (irq),
  .ctrl_q      (ctrl_q),
  .mask_q      (mask_q),
  .raw_q       (raw_q),
  .pres_q      (pres_q),
  .dma_q       (dma_q)
);

// File: tb/test_sdh_irq_core.sv
`timescale 1ns/1ps
module test_sdh_irq_core;

  localparam int AW = 6;
  localparam logic [AW-1:0] O_CTRL = 6'h00, O_MASK = 6'h08, O_RAW = 6'h0C,
                            O_MSKD = 6'h10, O_STAT = 6'h14, O_DMA = 6'h18,
                            O_NONE = 6'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_cmd_done = 0, ev_no_resp = 0, ev_data_done = 0, ev_autocmd_done = 0;
  logic ev_sdio = 0, ev_card_ins = 0, ev_card_rem = 0, ev_dma_tx = 0, ev_dma_rx = 0;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdh_irq_core #(.ADDR_W(AW)) i_sdh_irq_core (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_cmd_done(ev_cmd_done), .ev_no_resp(ev_no_resp),
    .ev_data_done(ev_data_done), .ev_autocmd_done(ev_autocmd_done),
    .ev_sdio(ev_sdio), .ev_card_ins(ev_card_ins), .ev_card_rem(ev_card_rem),
    .ev_dma_tx(ev_dma_tx), .ev_dma_rx(ev_dma_rx), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
    reg_addr = a;
    tick();
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", O_CTRL, 32'h0000_0300);
    rd_chk("R1 stat", O_STAT, 32'h0000_0100);
    rd_chk("R1 mask", O_MASK, 32'h0);
    rd_chk("R1 raw",  O_RAW,  32'h0);
    rd_chk("R1 mskd", O_MSKD, 32'h0);
    rd_chk("R1 dma",  O_DMA,  32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(O_CTRL, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl all ones", O_CTRL, 32'hFFFF_FFF8);
    wr(O_CTRL, 32'h0000_0305);
    rd_chk("R2 ctrl low", O_CTRL, 32'h0000_0300);
  endtask

  task automatic t_events();
    ev_no_resp = 1; tick(); ev_no_resp = 0;
    ev_cmd_done = 1; tick(); ev_cmd_done = 0;
    ev_data_done = 1; tick(); ev_data_done = 0;
    ev_autocmd_done = 1; tick(); ev_autocmd_done = 0;
    ev_sdio = 1; tick(); ev_sdio = 0;
    repeat (3) tick();
    rd_chk("R3 sticky events", O_RAW, 32'h0001_400E);
    wr(O_RAW, 32'hFFFF_FFFF);
    rd_chk("R3 cleared", O_RAW, 32'h0);
  endtask

  task automatic t_w1c();
    ev_no_resp = 1; ev_cmd_done = 1; ev_data_done = 1; tick();
    ev_no_resp = 0; ev_cmd_done = 0; ev_data_done = 0;
    wr(O_RAW, 32'h4);
    rd_chk("R4 raw offset clear", O_RAW, 32'hA);
    wr(O_MSKD, 32'h2);
    rd_chk("R4 masked offset clear", O_RAW, 32'h8);
    wr(O_RAW, 32'h0);
    rd_chk("R4 zero write keeps", O_RAW, 32'h8);
    wr(O_RAW, 32'h8);
  endtask

  task automatic t_masked();
    ev_sdio = 1; ev_autocmd_done = 1; tick(); ev_sdio = 0; ev_autocmd_done = 0;
    wr(O_MASK, 32'h0000_4004);
    rd_chk("R5 masked", O_MSKD, 32'h0000_4000);
    wr(O_MASK, 32'h0001_0000);
    rd_chk("R5 masked other", O_MSKD, 32'h0001_0000);
    wr(O_RAW, 32'hFFFF_FFFF);
    wr(O_MASK, 32'h0);
  endtask

  task automatic t_irq();
    wr(O_MASK, 32'h4);
    ev_cmd_done = 1; tick(); ev_cmd_done = 0;
    chk("R6 gate off", {31'b0, irq}, 32'h0);
    wr(O_CTRL, 32'h10);
    chk("R6 enable raises", {31'b0, irq}, 32'h1);
    wr(O_MASK, 32'h0);
    chk("R6 mask drops", {31'b0, irq}, 32'h0);
    wr(O_MASK, 32'h4);
    chk("R6 mask raises", {31'b0, irq}, 32'h1);
    wr(O_CTRL, 32'h0);
    chk("R6 disable drops", {31'b0, irq}, 32'h0);
    wr(O_CTRL, 32'h10);
    wr(O_RAW, 32'h4);
    chk("R6 clear drops", {31'b0, irq}, 32'h0);
    ev_cmd_done = 1; tick(); ev_cmd_done = 0;
    chk("R6 event raises same edge", {31'b0, irq}, 32'h1);
    wr(O_RAW, 32'h4);
    wr(O_MASK, 32'h0);
  endtask

  task automatic t_card();
    ev_card_rem = 1; tick(); ev_card_rem = 0;
    rd_chk("R7 remove raw", O_RAW, 32'h8000_0000);
    rd_chk("R7 remove stat", O_STAT, 32'h0);
    wr(O_MASK, 32'h8000_0000);
    chk("R7 remove irq", {31'b0, irq}, 32'h1);
    ev_card_ins = 1; tick(); ev_card_ins = 0;
    rd_chk("R7 insert raw", O_RAW, 32'h4000_0000);
    rd_chk("R7 insert stat", O_STAT, 32'h100);
    chk("R7 insert irq off", {31'b0, irq}, 32'h0);
    ev_card_ins = 1; ev_card_rem = 1; tick(); ev_card_ins = 0; ev_card_rem = 0;
    rd_chk("R7 both raw", O_RAW, 32'h8000_0000);
    rd_chk("R7 both stat", O_STAT, 32'h0);
    wr(O_MASK, 32'h0);
    wr(O_RAW, 32'hFFFF_FFFF);
  endtask

  task automatic t_stat();
    ev_card_ins = 1; tick(); ev_card_ins = 0;
    wr(O_STAT, 32'h0);
    rd_chk("R11 zero write keeps", O_STAT, 32'h100);
    wr(O_STAT, 32'h100);
    rd_chk("R11 clear present", O_STAT, 32'h0);
    ev_card_ins = 1; reg_addr = O_STAT; reg_wdata = 32'h100; reg_we = 1;
    tick();
    ev_card_ins = 0; reg_we = 0;
    rd_chk("R9 insert beats clear", O_STAT, 32'h100);
    wr(O_RAW, 32'hFFFF_FFFF);
  endtask

  task automatic t_dma();
    ev_dma_tx = 1; tick(); ev_dma_tx = 0;
    rd_chk("R8 tx", O_DMA, 32'h101);
    ev_dma_rx = 1; tick(); ev_dma_rx = 0;
    rd_chk("R8 rx", O_DMA, 32'h103);
    wr(O_DMA, 32'hFFFF_FC00);
    rd_chk("R8 high bits ignored", O_DMA, 32'h103);
    wr(O_DMA, 32'h1);
    rd_chk("R8 clear tx", O_DMA, 32'h102);
    wr(O_DMA, 32'h3FF);
    rd_chk("R8 clear all", O_DMA, 32'h0);
  endtask

  task automatic t_collide();
    ev_no_resp = 1; ev_data_done = 1; tick(); ev_no_resp = 0; ev_data_done = 0;
    ev_cmd_done = 1; reg_addr = O_RAW; reg_wdata = 32'hFFFF_FFFF; reg_we = 1;
    tick();
    ev_cmd_done = 0; reg_we = 0;
    rd_chk("R9 raw event beats clear", O_RAW, 32'h4);
    wr(O_RAW, 32'h4);
    ev_dma_tx = 1; tick(); ev_dma_tx = 0;
    ev_dma_rx = 1; reg_addr = O_DMA; reg_wdata = 32'h3FF; reg_we = 1;
    tick();
    ev_dma_rx = 0; reg_we = 0;
    rd_chk("R9 dma event beats clear", O_DMA, 32'h102);
    wr(O_DMA, 32'h3FF);
  endtask

  task automatic t_map();
    wr(O_MASK, 32'h0000_0008);
    rd_chk("R10 unmapped read", O_NONE, 32'h0);
    wr(O_NONE, 32'hFFFF_FFFF);
    rd_chk("R10 mask kept", O_MASK, 32'h0000_0008);
    rd_chk("R10 ctrl kept", O_CTRL, 32'h0000_0010);
    rd_chk("R10 dma kept", O_DMA, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_events();
    t_w1c();
    t_masked();
    t_irq();
    t_card();
    t_stat();
    t_dma();
    t_collide();
    t_map();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule